// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupt Detection

This block is a register-mapped general-purpose I/O controller for 64 pins. The pins are grouped into two 32-bit banks. Each bank has a direction word, a function-select word, an output word and a read-only input word. A pin that is handed to the GPIO function drives its pad from the output word when its direction bit marks it as an output. A pin that is handed to its alternate function takes its pad drive and output enable from a separate alternate-function path, which appears here as plain input ports.

The lowest 16 pins can raise interrupts. Each of these pins has three trigger bits (edge, high, low) that together pick level-low, level-high, rising, falling, both-edge or no detection. Pads pass through a two-flop synchronizer. A pending bit per pin records qualifying events. A per-pin enable gates each pending bit into one combined interrupt output. Pending bits are cleared through a level-style clear word: software writes a 1 to the pin's bit and later writes 0 back.

Access is through a simple synchronous register bus. Writes take effect at the clock edge where `bus_we` is high. Read data is registered, so it appears the cycle after the address is presented.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset, all direction, select, output, trigger, enable and clear words are 0. Every pin is therefore an input assigned to GPIO, `pad_oe` and `pad_out` are 0, no pin is pending and `irq` is 0.
- R2: The word addresses are as follows. Direction is at 0 (bank 0) and 1 (bank 1). Select is at 2/3. Output is at 4/5. Input is at 6/7. Trigger-edge is at 8, trigger-high at 9 and trigger-low at 10. Enable is at 11, clear at 12 and pending at 13. Pin p lives in bank p/32 at bit p mod 32, and written words read back unchanged.
- R3: For a pin with select bit 0, `pad_oe` equals its direction bit (1 = output) and `pad_out` equals its output bit. Both are registered, one cycle after the register changes.
- R4: For a pin with select bit 1, `pad_oe` and `pad_out` follow `alt_oe` and `alt_out` for that pin, one cycle later, whatever the direction and output bits hold.
- R5: The input words return the pad values after a two-flop synchronizer, whatever the direction or select setting.
- R6: Trigger code (edge,high,low)=(0,0,1) makes pending follow a low synchronized level. Code (0,1,0) makes pending follow a high level.
- R7: Code (1,1,0) sets pending on a rising synchronized edge. Code (1,0,1) sets pending on a falling edge.
- R8: Code (1,1,1) sets pending on either edge.
- R9: Code (0,0,0) holds the pin's pending bit at 0 whatever the pad does.
- R10: Edge-set pending bits stay set until cleared. While a pin's clear bit is 1, its pending bit reads 0 and edges are discarded. Releasing the clear does not bring a discarded edge back.
- R11: For a level-mode pin whose qualifying level persists, pending re-asserts once its clear bit returns to 0.
- R12: `irq` is the registered OR over pins of (pending AND enable). Pending is visible at address 13 even when the pin's enable is 0.
- R13: Only the low 16 bits of the trigger, enable, clear and pending words exist. Upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 64 | Pad input levels |
| pad_out | output | 64 | Pad output levels |
| pad_oe | output | 64 | Pad output enables |
| alt_out | input | 64 | Alternate-function output levels |
| alt_oe | input | 64 | Alternate-function output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The detector is exercised with one bank of six pins, each set to a different trigger code. All six pins see the same pad sequence: low, then high, then low. Each step therefore separates level-following pins from sticky edge pins, rising from falling, and disabled pins from armed ones. Clears are applied while a pad toggles, to show that edges are discarded under clear. Clears are also applied while a level persists, to show re-assertion after release. The pad path is checked with distinct patterns on bank 0, bank 1 and the alternate inputs, so that a swapped bank or a swapped source would show up.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BANK_W    = 32;
  localparam int unsigned NUM_BANKS = 2;

  localparam int unsigned REG_DIR      = 0;
  localparam int unsigned REG_SEL      = 2;
  localparam int unsigned REG_OUT      = 4;
  localparam int unsigned REG_IN       = 6;
  localparam int unsigned REG_TRIG_EDG = 8;
  localparam int unsigned REG_TRIG_HI  = 9;
  localparam int unsigned REG_TRIG_LO  = 10;
  localparam int unsigned REG_IRQ_EN   = 11;
  localparam int unsigned REG_IRQ_CLR  = 12;
  localparam int unsigned REG_IRQ_PEND = 13;

  typedef struct packed {
    logic edg;
    logic hi;
    logic lo;
  } trig_code_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] t_edge,
  input  logic [N-1:0] t_hi,
  input  logic [N-1:0] t_lo,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    trig_code_t code;
    logic       rise, fall, hit_edge, hit_lvl;

    always_comb begin
      code     = '{edg: t_edge[i], hi: t_hi[i], lo: t_lo[i]};
      rise     = lvl[i] & ~lvl_d[i];
      fall     = ~lvl[i] & lvl_d[i];
      hit_edge = (code.hi & rise) | (code.lo & fall);
      hit_lvl  = (code.hi & lvl[i]) | (code.lo & ~lvl[i]);
    end

    always_ff @(posedge clk) begin
      if (rst)           pend[i] <= 1'b0;
      else if (clr[i])   pend[i] <= 1'b0;
      else if (code.edg) pend[i] <= pend[i] | hit_edge;
      else               pend[i] <= hit_lvl;
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] out_val,
  input  logic [N-1:0] alt_out,
  input  logic [N-1:0] alt_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= (sel & alt_out) | (~sel & out_val);
      pad_oe  <= (sel & alt_oe)  | (~sel & dir);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned IRQ_PINS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] alt_oe,
  output logic                irq
);
  localparam int unsigned NB = NUM_PINS / DATA_W;

  logic [NUM_PINS-1:0] dir_q, sel_q, out_q, sync_in;
  logic [IRQ_PINS-1:0] t_edge_q, t_hi_q, t_lo_q, en_q, clr_q, pend;
  logic [DATA_W-1:0]   rd_val;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
    return a == ADDR_W'(r);
  endfunction

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        dir_q[b*DATA_W +: DATA_W] <= '0;
        sel_q[b*DATA_W +: DATA_W] <= '0;
        out_q[b*DATA_W +: DATA_W] <= '0;
      end else if (bus_we) begin
        if (hit(bus_addr, REG_DIR + b)) dir_q[b*DATA_W +: DATA_W] <= bus_wdata;
        if (hit(bus_addr, REG_SEL + b)) sel_q[b*DATA_W +: DATA_W] <= bus_wdata;
        if (hit(bus_addr, REG_OUT + b)) out_q[b*DATA_W +: DATA_W] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_edge_q <= '0;
      t_hi_q   <= '0;
      t_lo_q   <= '0;
      en_q     <= '0;
      clr_q    <= '0;
    end else if (bus_we) begin
      if (hit(bus_addr, REG_TRIG_EDG)) t_edge_q <= bus_wdata[IRQ_PINS-1:0];
      if (hit(bus_addr, REG_TRIG_HI))  t_hi_q   <= bus_wdata[IRQ_PINS-1:0];
      if (hit(bus_addr, REG_TRIG_LO))  t_lo_q   <= bus_wdata[IRQ_PINS-1:0];
      if (hit(bus_addr, REG_IRQ_EN))   en_q     <= bus_wdata[IRQ_PINS-1:0];
      if (hit(bus_addr, REG_IRQ_CLR))  clr_q    <= bus_wdata[IRQ_PINS-1:0];
    end
  end

  gpio_sync #(.W(NUM_PINS)) sync_i (
    .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(sync_in)
  );

  gpio_irq_detect #(.N(IRQ_PINS)) det_i (
    .clk(clk), .rst(rst), .lvl(sync_in[IRQ_PINS-1:0]),
    .t_edge(t_edge_q), .t_hi(t_hi_q), .t_lo(t_lo_q),
    .clr(clr_q), .pend(pend)
  );

  gpio_pad_mux #(.N(NUM_PINS)) mux_i (
    .clk(clk), .rst(rst), .dir(dir_q), .sel(sel_q), .out_val(out_q),
    .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < int'(NB); b++) begin
      if (hit(bus_addr, REG_DIR + b)) rd_val = dir_q[b*DATA_W +: DATA_W];
      if (hit(bus_addr, REG_SEL + b)) rd_val = sel_q[b*DATA_W +: DATA_W];
      if (hit(bus_addr, REG_OUT + b)) rd_val = out_q[b*DATA_W +: DATA_W];
      if (hit(bus_addr, REG_IN + b))  rd_val = sync_in[b*DATA_W +: DATA_W];
    end
    if (hit(bus_addr, REG_TRIG_EDG)) rd_val = DATA_W'(t_edge_q);
    if (hit(bus_addr, REG_TRIG_HI))  rd_val = DATA_W'(t_hi_q);
    if (hit(bus_addr, REG_TRIG_LO))  rd_val = DATA_W'(t_lo_q);
    if (hit(bus_addr, REG_IRQ_EN))   rd_val = DATA_W'(en_q);
    if (hit(bus_addr, REG_IRQ_CLR))  rd_val = DATA_W'(clr_q);
    if (hit(bus_addr, REG_IRQ_PEND)) rd_val = DATA_W'(pend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_val;
      irq       <= |(pend & en_q);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned IRQ_PINS = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                irq,
  input logic [IRQ_PINS-1:0] pend,
  input logic [IRQ_PINS-1:0] en_q,
  input logic [IRQ_PINS-1:0] clr_q,
  input logic [IRQ_PINS-1:0] t_edge_q,
  input logic [IRQ_PINS-1:0] t_hi_q,
  input logic [IRQ_PINS-1:0] t_lo_q,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] sel_q,
  input logic [NUM_PINS-1:0] alt_oe,
  input logic [NUM_PINS-1:0] pad_oe
);
  p_gpio_oe_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((pad_oe ^ $past(dir_q)) & ~$past(sel_q)) == '0));

  p_alt_oe_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((pad_oe ^ $past(alt_oe)) & $past(sel_q)) == '0));

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pend & ~$past(t_edge_q | t_hi_q | t_lo_q)) == '0));

  p_edge_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (($past(pend & t_edge_q & ~clr_q) & ~pend) == '0));

  p_clear_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (|clr_q) |=> ((pend & $past(clr_q)) == '0));

  p_irq_idle_r12: assert property (@(posedge clk) disable iff (rst)
    ((pend & en_q) == '0) |=> !irq);

  p_irq_raise_r12: assert property (@(posedge clk) disable iff (rst)
    ((pend & en_q) != '0) |=> irq);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .IRQ_PINS(IRQ_PINS)) chk_i (
  .clk(clk), .rst(rst), .irq(irq), .pend(pend), .en_q(en_q), .clr_q(clr_q),
  .t_edge_q(t_edge_q), .t_hi_q(t_hi_q), .t_lo_q(t_lo_q),
  .dir_q(dir_q), .sel_q(sel_q), .alt_oe(alt_oe), .pad_oe(pad_oe)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] pad_in = '0, pad_out, pad_oe;
  logic [63:0] alt_out = '0, alt_oe = '0;
  logic        irq;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  bit rd_flag = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read result once the registered data is out
  always @(negedge clk) begin
    if (rd_flag) begin
      check(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
      rd_flag = 1'b0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = 4'(a); bus_we = 1'b0;
    @(posedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_flag = 1'b1;
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    check("R1 irq", 64'(irq), 64'd0);
    rd(0, 32'h0, "R1 dir0");
    rd(13, 32'h0, "R1 pend");

    // R2/R3 bank mapping: pin 31 in bank 0, pin 32 in bank 1
    wr(1, 32'h0000_0001);
    wr(5, 32'h0000_0001);
    wr(0, 32'h8000_0000);
    wr(4, 32'h0000_0000);
    idle(2);
    check("R3 pad_oe", pad_oe, 64'h0000_0001_8000_0000);
    check("R3 pad_out", pad_out, 64'h0000_0001_0000_0000);
    rd(1, 32'h0000_0001, "R2 dir1 readback");
    rd(0, 32'h8000_0000, "R2 dir0 readback");

    // R4 alternate function on bank 1
    alt_oe  = 64'hA5A5_5A5A_0F0F_F0F0;
    alt_out = 64'h3C3C_C3C3_1111_2222;
    wr(3, 32'hFFFF_FFFF);
    idle(2);
    check("R4 pad_oe", pad_oe, 64'hA5A5_5A5A_8000_0000);
    check("R4 pad_out", pad_out, 64'h3C3C_C3C3_0000_0000);
    rd(3, 32'hFFFF_FFFF, "R2 sel1 readback");
    wr(3, 32'h0);

    // R5 input words, regardless of direction
    pad_in = 64'h1234_5678_9ABC_DEF0;
    idle(3);
    rd(6, 32'h9ABC_DEF0, "R5 in0");
    rd(7, 32'h1234_5678, "R5 in1");
    pad_in = '0;
    idle(3);

    // trigger codes: p0 rise, p1 fall, p2 both, p3 high, p4 low, p5 off
    wr(8,  32'h07);
    wr(9,  32'h0D);
    wr(10, 32'h16);
    wr(12, 32'hFFFF);
    wr(12, 32'h0);
    idle(3);
    rd(13, 32'h10, "R6 level-low pending");
    check("R12 irq masked", 64'(irq), 64'd0);

    pad_in[5:0] = 6'b111111;
    idle(4);
    rd(13, 32'h0D, "R7 R8 R9 after rise");

    pad_in[5:0] = 6'b000000;
    idle(4);
    rd(13, 32'h17, "R7 R10 after fall");

    // R12 enable gating
    wr(11, 32'h01);
    idle(2);
    check("R12 irq enabled", 64'(irq), 64'd1);
    wr(11, 32'h20);
    idle(2);
    check("R12 irq disabled pin", 64'(irq), 64'd0);

    // R10 clear held discards edges
    wr(12, 32'h0001);
    idle(2);
    rd(13, 32'h16, "R10 cleared");
    pad_in[0] = 1'b1;
    idle(4);
    rd(13, 32'h16, "R10 edge under clear");
    wr(12, 32'h0);
    idle(3);
    rd(13, 32'h16, "R10 no resurrection");

    // R11 level re-assert
    wr(12, 32'h0010);
    idle(2);
    rd(13, 32'h06, "R11 held clear");
    wr(12, 32'h0);
    idle(2);
    rd(13, 32'h16, "R11 re-asserted");
    wr(11, 32'h10);
    idle(2);
    check("R11 irq from level", 64'(irq), 64'd1);

    // R13 upper bits absent
    wr(8, 32'hFFFF_FFFF);
    rd(8, 32'h0000_FFFF, "R13 trig edge width");
    wr(11, 32'hFFFF_FFFF);
    rd(11, 32'h0000_FFFF, "R13 enable width");

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule